// File: doc/BRIEF.md
# Auto-Increment Packet Pointer Port

This block gives a host a byte-wide window into a packet buffer RAM of four pages of 2048 bytes each. The host loads a 16-bit pointer one byte at a time, then reads or writes packet bytes through a group of four adjacent data offsets. The pointer's low eleven bits are the byte offset inside a page. Two flag bits in its upper byte choose the page and the addressing style.

The page comes either from the head entry of the receive queue or from the current packet-number value. Both are inputs to the block. In auto-increment mode every data access moves the offset on by one and wraps inside the page. The bus address then does not matter. In fixed mode the pointer stays put, and the low two bits of the bus address are added to the offset, so a host can reach four neighbouring bytes without reloading the pointer. Read data comes back registered, one cycle after the request, and shows the byte that stood at the address before that same access moved the pointer.

Top module: `pkt_ptr_port`

## Requirements
- R1: After reset the pointer is zero, so both pointer bytes read back as 0x00.
- R2: A write to offset 6 replaces pointer bits 7:0, and a write to offset 7 replaces pointer bits 15:8. Each of these writes leaves the other byte unchanged.
- R3: A read at offset 7 returns pointer bits 15:8 ANDed with 0xF7, so bit 11 always reads as zero. A read at offset 6 returns pointer bits 7:0.
- R4: Offsets 8 to 11 are data accesses to the buffer RAM. A read at any offset other than 6 to 11 returns 0x00. A write there changes neither the pointer nor the RAM.
- R5: The RAM byte index is page*2048 + offset. The page is `rx_head` when pointer bit 15 is 1, and `pkt_num` when it is 0.
- R6: When pointer bit 14 is 0, a data access leaves the pointer unchanged. It reaches offset (pointer[10:0] + address[1:0]) mod 2048 within the page.
- R7: When pointer bit 14 is 1, a data access reaches offset pointer[10:0], whatever address[1:0] is. It then sets pointer[10:0] to (pointer[10:0]+1) mod 2048 and keeps bits 15:11.
- R8: A read accepted in one cycle raises `host_rvalid` for exactly the next cycle, with its byte on `host_rdata`. A data read returns the RAM byte at the address used before that access's own increment.
- R9: When `host_wr` and `host_rd` are high together, only the write is performed. No read data is returned, and the pointer advances at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Byte offset of the host access |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| rx_head | input | PAGE_W | Page number at the head of the receive queue |
| pkt_num | input | PAGE_W | Current packet-number page |

## Verification
Several properties are checked on every cycle:
- the pointer clears under reset;
- a byte write to the pointer keeps the other half;
- a fixed-mode data access holds the pointer steady, while an auto-mode one steps only the offset field, with wrap, and keeps the flags;
- read-valid timing and write priority follow from the strobes.

The RAM contents cannot be checked that way. Only the bench's scenarios can show that a byte lands at the index built from the selected page and the lane-adjusted offset, that the read value predates the increment, and that the readback mask and the unmapped offsets behave as specified.

// File: rtl/ptrport_pkg.sv
package ptrport_pkg;
  localparam int PTR_W   = 16;
  localparam int OFS_W   = 11;
  localparam int SEL_BIT = 15;
  localparam int AUTO_BIT = 14;
  localparam logic [7:0] HI_READ_MASK = 8'hF7;

  // Step the offset field by one, wrapping inside it; flag bits untouched.
  function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
    return {p[PTR_W-1:OFS_W], p[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1}};
  endfunction

  // Byte offset inside the page for a data access on a given lane.
  function automatic logic [OFS_W-1:0] lane_offset(input logic [PTR_W-1:0] p,
                                                    input logic [1:0] lane);
    if (p[AUTO_BIT]) return p[OFS_W-1:0];
    return p[OFS_W-1:0] + {{(OFS_W-2){1'b0}}, lane};
  endfunction
endpackage

// File: rtl/pp_pointer.sv
module pp_pointer
  import ptrport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  input  logic             step,
  input  logic             hold_access,
  output logic [PTR_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_lo) ptr_q[7:0] <= wdata;
    else if (wr_hi) ptr_q[15:8] <= wdata;
    else if (step)  ptr_q <= ptr_advance(ptr_q);
  end

  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> ptr_q == '0);
  a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> ptr_q[15:8] == $past(ptr_q[15:8]));
  a_r2_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> ptr_q[7:0] == $past(ptr_q[7:0]));
  a_r6_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_access |=> $stable(ptr_q));
  a_r7_step_offset: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ptr_q[OFS_W-1:0] == $past(ptr_q[OFS_W-1:0]) + 11'd1);
  a_r7_step_flags: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ptr_q[PTR_W-1:OFS_W] == $past(ptr_q[PTR_W-1:OFS_W]));
endmodule

// File: rtl/pp_ram.sv
module pp_ram #(
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pkt_ptr_port.sv
module pkt_ptr_port
  import ptrport_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int RAM_DEPTH = NUM_PAGES * PAGE_BYTES,
  localparam int RAM_AW = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_rvalid,
  input  logic [PAGE_W-1:0] rx_head,
  input  logic [PAGE_W-1:0] pkt_num
);
  localparam logic [3:0] OFS_PTR_LO = 4'd6;
  localparam logic [3:0] OFS_PTR_HI = 4'd7;

  logic [PTR_W-1:0]  ptr_q;
  logic              data_hit, data_acc, rd_fire, ptr_wr_lo, ptr_wr_hi;
  logic              step, hold_access, ram_we;
  logic [PAGE_W-1:0] page_sel;
  logic [RAM_AW-1:0] ram_addr;
  logic [7:0]        ram_q, reg_byte, reg_q;
  logic              sel_ram_q, rvalid_q;

  assign data_hit    = (host_addr[3:2] == 2'b10);
  assign data_acc    = data_hit && (host_wr || host_rd);
  assign rd_fire     = host_rd && !host_wr;
  assign ptr_wr_lo   = host_wr && (host_addr == OFS_PTR_LO);
  assign ptr_wr_hi   = host_wr && (host_addr == OFS_PTR_HI);
  assign step        = data_acc && ptr_q[AUTO_BIT];
  assign hold_access = data_acc && !ptr_q[AUTO_BIT];
  assign ram_we      = host_wr && data_hit;
  assign page_sel    = ptr_q[SEL_BIT] ? rx_head : pkt_num;
  assign ram_addr    = RAM_AW'({page_sel, lane_offset(ptr_q, host_addr[1:0])});

  pp_pointer u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_lo(ptr_wr_lo), .wr_hi(ptr_wr_hi),
    .wdata(host_wdata), .step(step), .hold_access(hold_access), .ptr_q(ptr_q)
  );

  pp_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(host_wdata), .rdata(ram_q)
  );

  always_comb begin
    case (host_addr)
      OFS_PTR_LO: reg_byte = ptr_q[7:0];
      OFS_PTR_HI: reg_byte = ptr_q[15:8] & HI_READ_MASK;
      default:    reg_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q  <= 1'b0;
      sel_ram_q <= 1'b0;
      reg_q     <= 8'h00;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) begin
        sel_ram_q <= data_hit;
        reg_q     <= reg_byte;
      end
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = sel_ram_q ? ram_q : reg_q;

  a_r8_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> host_rvalid);
  a_r8_valid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !host_rvalid);
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rd) |=> !host_rvalid);
  a_r3_hi_bit11_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && host_addr == OFS_PTR_HI) |=> host_rdata[3] == 1'b0);
  a_r4_unmapped_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !data_hit && host_addr != OFS_PTR_LO && host_addr != OFS_PTR_HI)
      |=> $stable(ptr_q));
endmodule

// File: tb/tb_pkt_ptr_port.sv
module tb_pkt_ptr_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic [1:0] rx_head = '0, pkt_num = '0;

  int n_cmp = 0, n_bad = 0;
  int m_ptr = 0;
  byte unsigned m_mem [8192];

  always #2 clk = ~clk;

  pkt_ptr_port dut (.*);

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int m_index(int lane);
    int pg, ofs;
    pg  = ((m_ptr >> 15) & 1) ? int'(rx_head) : int'(pkt_num);
    ofs = ((m_ptr >> 14) & 1) ? (m_ptr & 16'h7ff) : ((m_ptr + lane) & 16'h7ff);
    return pg * 2048 + ofs;
  endfunction

  // One bus cycle; the model is updated from the pre-edge state.
  task automatic bus(bit rd, bit wr, int a, int d, string req);
    int exp_rd, idx;
    bit is_data;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = 4'(a); host_wdata = 8'(d);
    is_data = (a >= 8 && a <= 11);
    idx = m_index(a & 3);
    exp_rd = 0;
    if (a == 6) exp_rd = m_ptr & 8'hff;
    else if (a == 7) exp_rd = (m_ptr >> 8) & 8'hf7;
    else if (is_data) exp_rd = m_mem[idx];
    if (wr) begin
      if (a == 6) m_ptr = (m_ptr & 16'hff00) | (d & 8'hff);
      else if (a == 7) m_ptr = (m_ptr & 16'h00ff) | ((d & 8'hff) << 8);
      else if (is_data) m_mem[idx] = 8'(d);
    end
    if (is_data && (rd || wr) && ((m_ptr >> 14) & 1))
      m_ptr = (m_ptr & 16'hf800) | ((m_ptr + 1) & 16'h7ff);
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    check({req, " rvalid"}, int'(host_rvalid), int'(rd && !wr));
    if (rd && !wr) check({req, " rdata"}, int'(host_rdata), exp_rd);
  endtask

  task automatic rd(int a, string req); bus(1, 0, a, 0, req); endtask
  task automatic wr(int a, int d, string req); bus(0, 1, a, d, req); endtask
  task automatic set_ptr(int p, string req);
    wr(6, p & 8'hff, req); wr(7, (p >> 8) & 8'hff, req);
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset pointer
    rd(6, "R1"); rd(7, "R1");
    // R4: unmapped offsets
    rd(0, "R4"); rd(13, "R4");
    // R2: separate byte loads
    wr(6, 8'h34, "R2"); rd(7, "R2");
    wr(7, 8'h12, "R2"); rd(6, "R2"); rd(7, "R2");
    // R3: high byte read mask
    wr(7, 8'hff, "R3"); rd(7, "R3"); rd(6, "R3");
    // R7/R5: fill every page in auto mode with scattered lanes
    for (int pg = 0; pg < 4; pg++) begin
      pkt_num = 2'(pg);
      set_ptr(16'h4000, "R7");
      for (int i = 0; i < 2048; i++) wr(8 + (i % 4), (i * 7 + pg * 13) & 255, "R7");
      rd(6, "R7 wrap"); rd(7, "R7 wrap");
    end
    // R6: fixed mode lanes
    pkt_num = 2'd2;
    set_ptr(16'h0100, "R6");
    for (int l = 0; l < 4; l++) rd(8 + l, "R6");
    rd(6, "R6"); rd(7, "R6");
    set_ptr(16'h07fe, "R6");
    rd(11, "R6 wrap"); rd(10, "R6 wrap");
    wr(10, 8'ha5, "R6"); rd(10, "R6"); rd(9, "R6");
    // R5: receive head page select
    rx_head = 2'd3; pkt_num = 2'd0;
    set_ptr(16'h8010, "R5"); rd(8, "R5"); rd(9, "R5");
    // R8: read before increment, across the wrap
    rx_head = 2'd1;
    set_ptr(16'hc7fe, "R8");
    for (int k = 0; k < 4; k++) rd(8, "R8");
    rd(6, "R8"); rd(7, "R8");
    // R3: bit 11 kept through stepping but masked on read
    set_ptr(16'h48ff, "R3"); rd(8, "R3"); rd(7, "R3"); rd(6, "R3");
    // R4: unmapped write leaves pointer and RAM
    wr(3, 8'h99, "R4"); wr(12, 8'h77, "R4"); rd(6, "R4"); rd(7, "R4");
    // R9: simultaneous read and write
    set_ptr(16'h4020, "R9");
    bus(1, 1, 9, 8'h5a, "R9"); rd(6, "R9");
    set_ptr(16'h4020, "R9"); rd(8, "R9");
    // Mixed traffic
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) wr(6, $urandom_range(0, 255), "R2");
      else if (op == 1) wr(7, $urandom_range(0, 255), "R2");
      else if (op == 2) rd($urandom_range(6, 7), "R3");
      else if (op == 3) begin rx_head = 2'($urandom); pkt_num = 2'($urandom); end
      else if (op == 4) wr(8 + $urandom_range(0, 3), $urandom_range(0, 255), "R6");
      else if (op == 5) bus(1, 1, 8 + $urandom_range(0, 3), $urandom_range(0, 255), "R9");
      else if (op == 6) rd($urandom_range(0, 15), "R4");
      else rd(8 + $urandom_range(0, 3), "R5");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule